// File: doc/BRIEF.md
# Configurable CRC Engine

This block computes a cyclic redundancy checksum over a stream of data writes. Software-style control comes through three write ports: a mode write that selects one of three generator polynomials and six transform options, a seed write that loads the running remainder, and a data write that carries one, two or four bytes together with a size tag. The current checksum is always visible, already transformed, on a read port. A busy flag and a ready signal pace the data stream.

One byte of data is folded into the remainder per clock. A single-byte write completes on the edge that accepts it. A wider write keeps the engine busy for the remaining bytes, and further data writes are held off by the ready/valid handshake until it finishes. The input transforms are one's complement, bit reversal inside each byte and reversal of byte order. The output transforms are one's complement, byte-order reversal and full-width bit reversal. Together they cover the common reflected and non-reflected checksum variants without any software post-processing.

Top module: `crc_engine`

## Requirements
- R1: After reset the checksum output is 0, busy is low, din_ready is high and the mode holds all zeros (CCITT polynomial, no transforms).
- R2: Mode bits [1:0] select the polynomial: 0 is CCITT 16-bit 0x1021, 1 is 16-bit 0x8005, 2 and 3 are 32-bit 0x04C11DB7. Each byte is folded in most significant bit first, with no implicit reflection.
- R3: din_size 0 carries one byte, 1 carries two bytes and 2 or 3 carry four bytes. The bytes of a write are folded in starting from the least significant byte.
- R4: A write of N bytes accepted on edge k has its first byte folded in at edge k and one more byte at each following edge. busy is high for exactly the N-1 cycles after edge k, so a single-byte write never raises busy.
- R5: din_ready is low while busy is high and in any cycle with a mode or seed write. A data write presented while din_ready is low is held and accepted later, not lost.
- R6: A seed write loads all 32 bits into the remainder, drops any bytes still pending, and shows on the checksum output after the next edge with busy low.
- R7: A mode write while busy is high is ignored. A mode write while idle takes effect on the next edge.
- R8: Input transforms: mode bit 4 inverts the written bytes, mode bit 2 reverses the bit order inside each byte, and mode bit 3 reverses the byte order inside the written size, so the most significant written byte goes first.
- R9: Output transforms over the active width: mode bit 5 reverses all bits, mode bit 6 reverses the byte order, and mode bit 7 inverts the result.
- R10: In the 16-bit polynomial modes only the low 16 bits of the remainder are used, and bits [31:16] of the checksum output read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 8 | New mode: polynomial select and transform options |
| seed_we | input | 1 | Seed write strobe |
| seed_wdata | input | 32 | Seed value loaded into the remainder |
| din_valid | input | 1 | Data write request |
| din_ready | output | 1 | Engine can accept a data write this cycle |
| din_data | input | 32 | Write data, least significant byte in bits [7:0] |
| din_size | input | 2 | Write size: 0 byte, 1 half-word, 2 or 3 word |
| busy | output | 1 | Bytes of an earlier write still being folded in |
| sum_out | output | 32 | Transformed checksum, zero-extended in 16-bit modes |

## Verification
A data write accepted on an edge changes sum_out right after that edge. A word write raises busy for the three edges that follow it, and a half-word for one. The bench drives on falling edges and samples at the falling edge that follows each rising edge of interest, so it can check the partial remainder after the first byte, the exact cycle busy drops, and the final value. Seed and mode writes take effect one edge after they are presented. The seed-abort and ignored-mode cases are therefore sampled on the falling edge just after that edge, and the final checksum is compared against a bit-serial model and against the well-known check values of the three standard variants.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int HALF_W     = WORD_W / 2;
    localparam int CNT_W      = $clog2(WORD_BYTES);
    localparam int NB_W       = CNT_W + 1;
    localparam int MODE_W     = 8;

    localparam logic [HALF_W-1:0] POLY16_CCITT = 16'h1021;
    localparam logic [HALF_W-1:0] POLY16_IBM   = 16'h8005;
    localparam logic [WORD_W-1:0] POLY32_ENET  = 32'h04C11DB7;

    typedef enum logic [1:0] {
        POLY_CCITT = 2'd0,
        POLY_IBM16 = 2'd1,
        POLY_ENET  = 2'd2,
        POLY_ENET2 = 2'd3
    } poly_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } size_e;

    typedef struct packed {
        logic  out_cmpl;
        logic  out_byterev;
        logic  out_bitrev;
        logic  in_cmpl;
        logic  in_byterev;
        logic  in_bitrev;
        poly_e poly;
    } mode_t;

    function automatic logic is_wide(input poly_e p);
        return p[1];
    endfunction

    function automatic logic [NB_W-1:0] bytes_of(input size_e s);
        case (s)
            SZ_BYTE: return NB_W'(1);
            SZ_HALF: return NB_W'(2);
            default: return NB_W'(WORD_BYTES);
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/crc_in_prep.sv
module crc_in_prep
    import crc_pkg::*;
(
    input  logic [WORD_W-1:0] data,
    input  size_e             size,
    input  mode_t             mode,
    output logic [WORD_W-1:0] lanes,
    output logic [NB_W-1:0]   nbytes
);
    logic [BYTE_W-1:0] tb [WORD_BYTES];

    assign nbytes = bytes_of(size);

    // complement and per-byte bit reversal, one lane per byte
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] raw;
        assign raw   = mode.in_cmpl ? ~data[g*BYTE_W +: BYTE_W] : data[g*BYTE_W +: BYTE_W];
        assign tb[g] = mode.in_bitrev ? rev_byte(raw) : raw;
    end

    // byte-order reversal inside the written size; lane 0 is folded first
    always_comb begin
        int n;
        n = int'(nbytes);
        lanes = '0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            int src;
            src = (mode.in_byterev && i < n) ? (n - 1 - i) : i;
            lanes[i*BYTE_W +: BYTE_W] = tb[src];
        end
    end
endmodule

// File: rtl/crc_step.sv
module crc_step
    import crc_pkg::*;
(
    input  logic [WORD_W-1:0] crc_in,
    input  logic [BYTE_W-1:0] din,
    input  poly_e             poly,
    output logic [WORD_W-1:0] crc_out
);
    logic [WORD_W-1:0] s32 [BYTE_W+1];
    logic [HALF_W-1:0] s16 [BYTE_W+1];
    logic [HALF_W-1:0] p16;

    assign p16    = (poly == POLY_IBM16) ? POLY16_IBM : POLY16_CCITT;
    assign s32[0] = crc_in ^ {din, {(WORD_W-BYTE_W){1'b0}}};
    assign s16[0] = crc_in[HALF_W-1:0] ^ {din, {(HALF_W-BYTE_W){1'b0}}};

    // eight unrolled shift stages per width
    for (genvar k = 0; k < BYTE_W; k++) begin : g_stage
        assign s32[k+1] = s32[k][WORD_W-1]
                        ? ({s32[k][WORD_W-2:0], 1'b0} ^ POLY32_ENET)
                        :  {s32[k][WORD_W-2:0], 1'b0};
        assign s16[k+1] = s16[k][HALF_W-1]
                        ? ({s16[k][HALF_W-2:0], 1'b0} ^ p16)
                        :  {s16[k][HALF_W-2:0], 1'b0};
    end

    assign crc_out = is_wide(poly) ? s32[BYTE_W] : {{HALF_W{1'b0}}, s16[BYTE_W]};
endmodule

// File: rtl/crc_out_fmt.sv
module crc_out_fmt
    import crc_pkg::*;
(
    input  logic [WORD_W-1:0] crc,
    input  mode_t             mode,
    output logic [WORD_W-1:0] sum
);
    logic              wide;
    logic [WORD_W-1:0] rev32;
    logic [HALF_W-1:0] rev16;
    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] brev;
    logic [WORD_W-1:0] swp;
    logic [WORD_W-1:0] mask;

    assign wide = is_wide(mode.poly);
    assign mask = wide ? '1 : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

    for (genvar g = 0; g < WORD_W; g++) begin : g_r32
        assign rev32[g] = crc[WORD_W-1-g];
    end
    for (genvar g = 0; g < HALF_W; g++) begin : g_r16
        assign rev16[g] = crc[HALF_W-1-g];
    end

    assign base = crc & mask;
    assign brev = !mode.out_bitrev ? base
                : (wide ? rev32 : {{HALF_W{1'b0}}, rev16});

    always_comb begin
        swp = brev;
        if (mode.out_byterev) begin
            swp = '0;
            if (wide) begin
                for (int i = 0; i < WORD_BYTES; i++)
                    swp[i*BYTE_W +: BYTE_W] = brev[(WORD_BYTES-1-i)*BYTE_W +: BYTE_W];
            end else begin
                for (int i = 0; i < WORD_BYTES/2; i++)
                    swp[i*BYTE_W +: BYTE_W] = brev[(WORD_BYTES/2-1-i)*BYTE_W +: BYTE_W];
            end
        end
    end

    assign sum = mode.out_cmpl ? (swp ^ mask) : swp;
endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              seed_we,
    input  logic [WORD_W-1:0] seed_wdata,
    input  logic              din_valid,
    output logic              din_ready,
    input  logic [WORD_W-1:0] din_data,
    input  logic [1:0]        din_size,
    output logic              busy,
    output logic [WORD_W-1:0] sum_out
);
    mode_t                    mode_q;
    logic [WORD_W-1:0]        crc_q;
    logic [WORD_W-BYTE_W-1:0] pend_q;
    logic [CNT_W-1:0]         rem_q;

    logic [WORD_W-1:0] lanes;
    logic [NB_W-1:0]   nbytes;
    logic [BYTE_W-1:0] cur_byte;
    logic [WORD_W-1:0] crc_next;
    logic              accept;

    assign busy      = (rem_q != '0);
    assign din_ready = !busy && !seed_we && !mode_we;
    assign accept    = din_valid && din_ready;
    assign cur_byte  = busy ? pend_q[BYTE_W-1:0] : lanes[BYTE_W-1:0];

    crc_in_prep u_prep (
        .data   (din_data),
        .size   (size_e'(din_size)),
        .mode   (mode_q),
        .lanes  (lanes),
        .nbytes (nbytes)
    );

    crc_step u_step (
        .crc_in  (crc_q),
        .din     (cur_byte),
        .poly    (mode_q.poly),
        .crc_out (crc_next)
    );

    crc_out_fmt u_fmt (
        .crc  (crc_q),
        .mode (mode_q),
        .sum  (sum_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            crc_q  <= '0;
            pend_q <= '0;
            rem_q  <= '0;
        end else begin
            if (mode_we && !busy)
                mode_q <= mode_t'(mode_wdata);
            if (seed_we) begin
                crc_q <= seed_wdata;
                rem_q <= '0;
            end else if (busy) begin
                crc_q  <= crc_next;
                pend_q <= pend_q >> BYTE_W;
                rem_q  <= rem_q - CNT_W'(1);
            end else if (accept) begin
                crc_q  <= crc_next;
                pend_q <= lanes[WORD_W-1:BYTE_W];
                rem_q  <= CNT_W'(nbytes - NB_W'(1));
            end
        end
    end
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk
    import crc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mode_we,
    input logic              seed_we,
    input logic              din_valid,
    input logic              din_ready,
    input logic [1:0]        din_size,
    input logic              busy,
    input logic [WORD_W-1:0] sum_out,
    input mode_t             mode_q
);
    a_r5_no_ready_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !din_ready);

    a_r5_ctrl_blocks_data: assert property (@(posedge clk) disable iff (rst)
        (mode_we || seed_we) |-> !din_ready);

    a_r4_word_raises_busy: assert property (@(posedge clk) disable iff (rst)
        (din_valid && din_ready && din_size != 2'd0) |=> busy);

    a_r4_byte_no_busy: assert property (@(posedge clk) disable iff (rst)
        (din_valid && din_ready && din_size == 2'd0) |=> !busy);

    a_r6_seed_clears_busy: assert property (@(posedge clk) disable iff (rst)
        seed_we |=> !busy);

    a_r7_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_q));

    a_r10_zero_ext: assert property (@(posedge clk) disable iff (rst)
        !is_wide(mode_q.poly) |-> (sum_out[WORD_W-1:HALF_W] == '0));
endmodule

bind crc_engine crc_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_we   (mode_we),
    .seed_we   (seed_we),
    .din_valid (din_valid),
    .din_ready (din_ready),
    .din_size  (din_size),
    .busy      (busy),
    .sum_out   (sum_out),
    .mode_q    (mode_q)
);

// File: tb/crc_engine_bench.sv
`timescale 1ns/1ps
module crc_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_we = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic        seed_we = 1'b0;
    logic [31:0] seed_wdata = '0;
    logic        din_valid = 1'b0;
    logic        din_ready;
    logic [31:0] din_data = '0;
    logic [1:0]  din_size = '0;
    logic        busy;
    logic [31:0] sum_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    crc_engine u_crc_engine (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .seed_we(seed_we), .seed_wdata(seed_wdata), .din_valid(din_valid),
        .din_ready(din_ready), .din_data(din_data), .din_size(din_size),
        .busy(busy), .sum_out(sum_out)
    );

    // ---------------- reference model (bit-serial) ----------------
    function automatic [31:0] m_byte(input [31:0] c, input [7:0] b, input [1:0] p);
        for (int i = 7; i >= 0; i--) begin
            if (p[1]) begin
                logic fb;
                fb = c[31] ^ b[i];
                c = c << 1;
                if (fb) c = c ^ 32'h04C11DB7;
            end else begin
                logic fb;
                fb = c[15] ^ b[i];
                c = {16'h0, c[14:0], 1'b0};
                if (fb) c = c ^ ((p == 2'd1) ? 32'h8005 : 32'h1021);
            end
        end
        return c;
    endfunction

    function automatic [31:0] m_feed(input [31:0] c, input [31:0] d, input [1:0] sz, input [7:0] m);
        int n;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        for (int k = 0; k < n; k++) begin
            logic [7:0] b, r;
            b = d[8*((m[3]) ? (n-1-k) : k) +: 8];
            if (m[4]) b = ~b;
            for (int j = 0; j < 8; j++) r[j] = b[7-j];
            if (m[2]) b = r;
            c = m_byte(c, b, m[1:0]);
        end
        return c;
    endfunction

    function automatic [31:0] m_sum(input [31:0] c, input [7:0] m);
        int w;
        logic [31:0] v, r, mask;
        w = m[1] ? 32 : 16;
        mask = m[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        v = c & mask;
        if (m[5]) begin
            r = '0;
            for (int j = 0; j < w; j++) r[j] = v[w-1-j];
            v = r;
        end
        if (m[6]) v = m[1] ? {v[7:0], v[15:8], v[23:16], v[31:24]} : {16'h0, v[7:0], v[15:8]};
        if (m[7]) v = v ^ mask;
        return v;
    endfunction

    // ---------------- helpers ----------------
    task automatic check(input string req, input [31:0] act, input [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_mode(input [7:0] m);
        @(negedge clk); mode_we = 1'b1; mode_wdata = m;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic wr_seed(input [31:0] s);
        @(negedge clk); seed_we = 1'b1; seed_wdata = s;
        @(negedge clk); seed_we = 1'b0;
    endtask

    // returns at the falling edge just after the accepting rising edge
    task automatic send(input [31:0] d, input [1:0] sz);
        @(negedge clk); din_valid = 1'b1; din_data = d; din_size = sz;
        while (!din_ready) @(negedge clk);
        @(negedge clk); din_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R1 sum after reset", sum_out, 32'h0);
        check("R1 busy after reset", {31'h0, busy}, 32'h0);
        check("R1 ready after reset", {31'h0, din_ready}, 32'h1);
    endtask

    task automatic t_ccitt();
        wr_mode(8'h00); wr_seed(32'hFFFF);
        send(32'h34333231, 2'd2); send(32'h38373635, 2'd2); send(32'h39, 2'd0);
        wait_idle();
        check("R2 R3 CCITT check value", sum_out, 32'h0000_29B1);
    endtask

    task automatic t_ibm16();
        wr_mode(8'h25); wr_seed(32'h0);
        send(32'h3231, 2'd1); send(32'h3433, 2'd1); send(32'h3635, 2'd1);
        send(32'h3837, 2'd1); send(32'h39, 2'd0);
        wait_idle();
        check("R2 R8 R9 reflected 0x8005 check value", sum_out, 32'h0000_BB3D);
    endtask

    task automatic t_crc32();
        wr_mode(8'hAE); wr_seed(32'hFFFF_FFFF);
        send(32'h31323334, 2'd2); send(32'h35363738, 2'd3); send(32'h39, 2'd0);
        wait_idle();
        check("R2 R3 R8 R9 32-bit check value with byte reverse", sum_out, 32'hCBF4_3926);
    endtask

    task automatic t_timing();
        logic [31:0] e;
        wr_mode(8'h02); wr_seed(32'h0);
        send(32'hA1B2C3D4, 2'd2);
        check("R4 busy after word accept", {31'h0, busy}, 32'h1);
        check("R5 ready low while busy", {31'h0, din_ready}, 32'h0);
        check("R4 first byte folded at accept edge", sum_out, m_feed(32'h0, 32'hD4, 2'd0, 8'h02));
        @(negedge clk); check("R4 busy second cycle", {31'h0, busy}, 32'h1);
        @(negedge clk); check("R4 busy third cycle", {31'h0, busy}, 32'h1);
        @(negedge clk); check("R4 idle after four bytes", {31'h0, busy}, 32'h0);
        e = m_feed(32'h0, 32'hA1B2C3D4, 2'd2, 8'h02);
        check("R3 R4 word result", sum_out, e);
        send(32'h5566, 2'd1);
        check("R4 busy after half accept", {31'h0, busy}, 32'h1);
        @(negedge clk); check("R4 idle after two bytes", {31'h0, busy}, 32'h0);
        e = m_feed(e, 32'h5566, 2'd1, 8'h02);
        check("R3 half result", sum_out, e);
        send(32'h77, 2'd0);
        check("R4 byte never busy", {31'h0, busy}, 32'h0);
        check("R4 byte result at accept edge", sum_out, m_feed(e, 32'h77, 2'd0, 8'h02));
    endtask

    task automatic t_stall();
        logic [31:0] e;
        wr_mode(8'h01); wr_seed(32'h1D0F);
        send(32'h01020304, 2'd2);
        check("R5 ready low right after word", {31'h0, din_ready}, 32'h0);
        send(32'hF0E0D0C0, 2'd2);
        wait_idle();
        e = m_feed(32'h1D0F, 32'h01020304, 2'd2, 8'h01);
        e = m_feed(e, 32'hF0E0D0C0, 2'd2, 8'h01);
        check("R5 stalled write not lost", sum_out, m_sum(e, 8'h01));
    endtask

    task automatic t_seed_abort();
        wr_mode(8'h02); wr_seed(32'h0);
        send(32'h11111111, 2'd2);
        wr_seed(32'hDEADBEEF);
        check("R6 seed drops pending bytes", {31'h0, busy}, 32'h0);
        check("R6 seed visible next edge", sum_out, 32'hDEADBEEF);
    endtask

    task automatic t_mode_ignored();
        wr_mode(8'h02); wr_seed(32'h12345678);
        send(32'hCAFEF00D, 2'd2);
        wr_mode(8'h40);
        wait_idle();
        check("R7 mode write during busy ignored", sum_out,
              m_feed(32'h12345678, 32'hCAFEF00D, 2'd2, 8'h02));
    endtask

    task automatic t_in_cmpl();
        wr_mode(8'h10); wr_seed(32'h0);
        send(32'hCDCE, 2'd1);
        wait_idle();
        check("R8 input complement", sum_out, m_feed(32'h0, 32'h3231, 2'd1, 8'h00));
    endtask

    task automatic t_out_fmt();
        wr_mode(8'h00); wr_seed(32'hFFFF1234);
        check("R10 16-bit zero extended", sum_out, 32'h0000_1234);
        wr_mode(8'h40); check("R9 16-bit byte reverse", sum_out, 32'h0000_3412);
        wr_mode(8'h20); check("R9 16-bit bit reverse", sum_out, 32'h0000_2C48);
        wr_mode(8'h80); check("R9 16-bit complement", sum_out, 32'h0000_EDCB);
        wr_mode(8'h42); wr_seed(32'h11223344);
        check("R9 32-bit byte reverse", sum_out, 32'h4433_2211);
        wr_mode(8'h22); check("R9 32-bit bit reverse", sum_out, 32'h22CC_4488);
        wr_mode(8'h82); check("R9 32-bit complement", sum_out, 32'hEEDD_CCBB);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ccitt();
        t_ibm16();
        t_crc32();
        t_timing();
        t_stall();
        t_seed_abort();
        t_mode_ignored();
        t_in_cmpl();
        t_out_fmt();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule